// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery and Claim Unit

This block sits behind the source-detection stage of a direct-mode interrupt controller. Each interrupt source has a target word that routes it to one hart and gives it a priority. For every hart the unit picks the best eligible source and drives that hart's external interrupt line. Software running on a hart reads a top-interrupt word to see what is waiting. It reads a claim word to take that source, and the claim read also clears the source's pending bit.

Pending state lives here. A one-cycle pulse on `src_pend_set` marks a source pending, and a claim clears it. Source enables arrive as a level input from elsewhere in the controller. Registers are reached over a simple 32-bit word bus. Writes take effect at the clock edge of the request. Read data returns one cycle later, marked by `bus_rvalid`.

Top module: `hart_irq_deliver`

## Requirements
- R1: After reset every pending bit, delivery enable, force bit, threshold and target word is zero, every hart line is low, and reads of these registers return 0.
- R2: The target word of source n (n from 1) sits at byte address 0x3004 + 4*(n-1). It stores a hart index in bits starting at 18, as many bits as are needed to index the harts, and an 8-bit priority in bits 7:0. Readback shows exactly those fields, with all other bits 0.
- R3: Among a hart's eligible sources the one with the smallest priority number wins, and ties go to the lowest source number. A stored priority of 0 is used and reported as 1.
- R4: The threshold is bits 7:0 of the word at hart base + 0x08. A value of 0 lets every priority through. Any other value admits only sources whose priority number is strictly less than it.
- R5: The top-interrupt word at hart base + 0x18 returns the winner's number in bits 25:16 and its priority in bits 7:0, or 0 when there is no winner. Reading it changes nothing. Hart h's base is 0x4000 + 0x20*h.
- R6: A read of the claim word at hart base + 0x1C returns the same value as top-interrupt and clears the winner's pending bit at that edge. If a new pending pulse for the same source arrives in the same cycle, the source stays pending.
- R7: The delivery enable is bit 0 at hart base + 0x00 (1 delivers, 0 blocks). The hart line is high only while it is 1, and the enable does not change what top-interrupt reports.
- R8: The force bit is bit 0 at hart base + 0x04. When delivery is enabled it raises the hart line even with no eligible source. A claim that returns 0 clears force.
- R9: A source is eligible for hart h only if it is pending, its `src_en` bit is 1, and its target hart index equals h.
- R10: `bus_rvalid` is high for exactly the one cycle after each read request and low otherwise. Writes to top-interrupt, claim and unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NSRC | Source enables, bit n-1 for source n |
| src_pend_set | input | NSRC | One-cycle pending pulses, bit n-1 for source n |
| bus_req | input | 1 | Bus access request, one word per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 16 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| hart_irq | output | NHART | External interrupt line per hart |

## Verification
The assertions assume one bus access per cycle, so at most one claim can clear a pending bit in any cycle. They also assume word-aligned addresses. The stimulus drives every request for exactly one cycle, between falling edges, and never overlaps two requests. Pending pulses and enables change only at falling edges. The one deliberate overlap, a pending pulse for the source being claimed, lands in the same cycle so that the set-wins rule is exercised on purpose.

// File: rtl/hid_pkg.sv
package hid_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned HART_LSB = 18;
  localparam logic [15:0] TGT_BASE  = 16'h3004;
  localparam logic [15:0] HART_BASE = 16'h4000;
  localparam int unsigned HART_STRIDE_LG = 5;
  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THR   = 5'h08;
  localparam logic [4:0] OFF_TOP   = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  function automatic logic [31:0] pack_top(input logic [ID_W-1:0] id,
                                           input logic [PRIO_W-1:0] prio);
    pack_top = {6'd0, id, 8'd0, prio};
  endfunction
endpackage

// File: rtl/hid_rst_sync.sv
module hid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hid_pending.sv
module hid_pending #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: a claim clears exactly the claimed source unless a set coincides
  a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R6: one bus access per cycle, so at most one source is cleared
  a_r6_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));
endmodule

// File: rtl/hid_hart_ctl.sv
module hid_hart_ctl
  import hid_pkg::*;
#(
  parameter int unsigned NSRC     = 8,
  parameter int unsigned HART_W   = 1,
  parameter int unsigned HART_IDX = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              live_i,
  input  logic [NSRC-1:0][PRIO_W-1:0]  tgt_prio_i,
  input  logic [NSRC-1:0][HART_W-1:0]  tgt_hart_i,
  input  logic                         wr_deliv_i,
  input  logic                         wr_force_i,
  input  logic                         wr_thr_i,
  input  logic [PRIO_W-1:0]            wdata_i,
  input  logic                         claim_i,
  output logic                         deliv_o,
  output logic                         force_o,
  output logic [PRIO_W-1:0]            thr_o,
  output logic [31:0]                  top_o,
  output logic [NSRC-1:0]              clr_o,
  output logic                         irq_o
);
  logic              deliv_q, deliv_d;
  logic              force_q, force_d;
  logic [PRIO_W-1:0] thr_q, thr_d;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic [NSRC-1:0]   best_oh;

  // winner selection: strict less keeps the lowest source on ties
  always_comb begin
    logic [PRIO_W-1:0] eff;
    logic              ok;
    best_id   = '0;
    best_prio = '0;
    best_oh   = '0;
    for (int i = 0; i < NSRC; i++) begin
      eff = (tgt_prio_i[i] == '0) ? PRIO_W'(1) : tgt_prio_i[i];
      ok  = live_i[i] && (tgt_hart_i[i] == HART_W'(HART_IDX)) &&
            ((thr_q == '0) || (eff < thr_q));
      if (ok && ((best_id == '0) || (eff < best_prio))) begin
        best_id   = ID_W'(i + 1);
        best_prio = eff;
        best_oh   = NSRC'(1) << i;
      end
    end
  end

  always_comb begin
    deliv_d = wr_deliv_i ? wdata_i[0] : deliv_q;
    thr_d   = wr_thr_i   ? wdata_i    : thr_q;
    if (wr_force_i)                        force_d = wdata_i[0];
    else if (claim_i && best_id == '0)     force_d = 1'b0;
    else                                   force_d = force_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deliv_q <= 1'b0;
      force_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      deliv_q <= deliv_d;
      force_q <= force_d;
      thr_q   <= thr_d;
    end
  end

  assign clr_o   = claim_i ? best_oh : '0;
  assign top_o   = pack_top(best_id, best_prio);
  assign irq_o   = deliv_q && ((best_id != '0) || force_q);
  assign deliv_o = deliv_q;
  assign force_o = force_q;
  assign thr_o   = thr_q;

  // R4: a reported winner always passes the threshold
  a_r4_thresh_respected: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_q != '0) && (top_o[25:16] != '0)) |-> (top_o[7:0] < thr_q));

  // R3: a reported winner never carries priority 0
  a_r3_prio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (top_o[25:16] != '0) |-> (top_o[7:0] != '0));
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned NHART = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_pend_set,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [15:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic             bus_rvalid,
  output logic [31:0]      bus_rdata,
  output logic [NHART-1:0] hart_irq
);
  localparam int unsigned HART_W = (NHART > 1) ? $clog2(NHART) : 1;
  localparam logic [15:0] TGT_END  = TGT_BASE + 16'(4 * NSRC);
  localparam logic [15:0] HART_END = HART_BASE + 16'(32 * NHART);

  logic rst_s;
  hid_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s));

  // address decode
  logic        is_tgt, is_hart;
  logic [15:0] tgt_off, hart_off;
  logic [15:0] tgt_idx, hart_sel;
  logic [4:0]  reg_off;
  logic        do_wr, do_rd;

  always_comb begin
    tgt_off  = bus_addr - TGT_BASE;
    hart_off = bus_addr - HART_BASE;
    is_tgt   = (bus_addr >= TGT_BASE) && (bus_addr < TGT_END) && (bus_addr[1:0] == 2'b00);
    is_hart  = (bus_addr >= HART_BASE) && (bus_addr < HART_END);
    tgt_idx  = tgt_off >> 2;
    hart_sel = hart_off >> HART_STRIDE_LG;
    reg_off  = hart_off[4:0];
    do_wr    = bus_req && bus_we;
    do_rd    = bus_req && !bus_we;
  end

  // source target words
  logic [NSRC-1:0][PRIO_W-1:0] tgt_prio_q;
  logic [NSRC-1:0][HART_W-1:0] tgt_hart_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_tgt
    logic wr_s;
    assign wr_s = do_wr && is_tgt && (tgt_idx == 16'(s));
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        tgt_prio_q[s] <= '0;
        tgt_hart_q[s] <= '0;
      end else if (wr_s) begin
        tgt_prio_q[s] <= bus_wdata[PRIO_W-1:0];
        tgt_hart_q[s] <= bus_wdata[HART_LSB +: HART_W];
      end
    end
  end

  // pending state
  logic [NSRC-1:0] pend, clr_any;
  logic [NSRC-1:0] clr_h [NHART];

  always_comb begin
    clr_any = '0;
    for (int h = 0; h < NHART; h++) clr_any |= clr_h[h];
  end

  hid_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_s), .set_i(src_pend_set), .clr_i(clr_any), .pend_o(pend)
  );

  // per-hart control
  logic [NHART-1:0]  deliv_v, force_v;
  logic [PRIO_W-1:0] thr_v [NHART];
  logic [31:0]       top_v [NHART];

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    logic sel_h;
    assign sel_h = is_hart && (hart_sel == 16'(h));
    hid_hart_ctl #(.NSRC(NSRC), .HART_W(HART_W), .HART_IDX(h)) u_ctl (
      .clk(clk), .rst_n(rst_s),
      .live_i(pend & src_en),
      .tgt_prio_i(tgt_prio_q), .tgt_hart_i(tgt_hart_q),
      .wr_deliv_i(do_wr && sel_h && reg_off == OFF_DELIV),
      .wr_force_i(do_wr && sel_h && reg_off == OFF_FORCE),
      .wr_thr_i(do_wr && sel_h && reg_off == OFF_THR),
      .wdata_i(bus_wdata[PRIO_W-1:0]),
      .claim_i(do_rd && sel_h && reg_off == OFF_CLAIM),
      .deliv_o(deliv_v[h]), .force_o(force_v[h]), .thr_o(thr_v[h]),
      .top_o(top_v[h]), .clr_o(clr_h[h]), .irq_o(hart_irq[h])
    );
  end

  // read path
  logic [31:0] rd_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    rd_d = '0;
    if (is_tgt) begin
      for (int s = 0; s < NSRC; s++) begin
        if (tgt_idx == 16'(s)) begin
          rd_d[PRIO_W-1:0]          = tgt_prio_q[s];
          rd_d[HART_LSB +: HART_W]  = tgt_hart_q[s];
        end
      end
    end else if (is_hart) begin
      for (int h = 0; h < NHART; h++) begin
        if (hart_sel == 16'(h)) begin
          case (reg_off)
            OFF_DELIV: rd_d = {31'd0, deliv_v[h]};
            OFF_FORCE: rd_d = {31'd0, force_v[h]};
            OFF_THR:   rd_d = {24'd0, thr_v[h]};
            OFF_TOP,
            OFF_CLAIM: rd_d = top_v[h];
            default:   rd_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= do_rd;
      if (do_rd) rdata_q <= rd_d;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  // R10: a read request is answered in the next cycle
  a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R10: no response without a read request
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_s)
    !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

// File: tb/hart_irq_deliver_test.sv
module hart_irq_deliver_test;
  localparam int NSRC = 8;
  localparam int NHART = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSRC-1:0]  src_en;
  logic [NSRC-1:0]  src_pend_set;
  logic             bus_req, bus_we;
  logic [15:0]      bus_addr;
  logic [31:0]      bus_wdata;
  logic             bus_rvalid;
  logic [31:0]      bus_rdata;
  logic [NHART-1:0] hart_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hart_irq_deliver #(.NSRC(NSRC), .NHART(NHART)) uut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_pend_set(src_pend_set),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .hart_irq(hart_irq)
  );

  function automatic logic [31:0] tw(input int id, input int prio);
    tw = (32'(id) << 16) | 32'(prio);
  endfunction
  function automatic logic [15:0] hbase(input int h);
    hbase = 16'h4000 + 16'(h * 32);
  endfunction
  function automatic logic [15:0] taddr(input int n);
    taddr = 16'h3004 + 16'((n - 1) * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pend(input logic [NSRC-1:0] m);
    src_pend_set = m;
    @(negedge clk);
    src_pend_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(hart_irq), 32'd0);
    bus_read(hbase(0) + 16'h18, d); check("R1 top h0", d, 32'd0);
    bus_read(taddr(1), d);          check("R1 target", d, 32'd0);
    bus_read(hbase(1) + 16'h08, d); check("R1 thr h1", d, 32'd0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    bus_read(hbase(0), d);
    check("R10 rvalid high", 32'(bus_rvalid), 32'd1);
    @(negedge clk);
    check("R10 rvalid low", 32'(bus_rvalid), 32'd0);
    bus_write(hbase(0) + 16'h18, 32'hFF);
    bus_read(hbase(0), d); check("R10 write to top ignored", d, 32'd0);
  endtask

  task automatic t_target();
    logic [31:0] d;
    bus_write(taddr(3), (32'd1 << 18) | (32'd1 << 19) | 32'h125);
    bus_read(taddr(3), d); check("R2 readback", d, (32'd1 << 18) | 32'h25);
  endtask

  task automatic t_select();
    logic [31:0] d;
    src_en = '1;
    bus_write(taddr(1), 32'd5);
    bus_write(taddr(2), 32'd3);
    bus_write(taddr(3), 32'd3);
    bus_write(taddr(4), (32'd1 << 18) | 32'd1);
    pend(8'b0000_1111);
    bus_read(hbase(0) + 16'h18, d); check("R3 tie lowest", d, tw(2, 3));
    bus_read(hbase(0) + 16'h18, d); check("R5 top no side effect", d, tw(2, 3));
    bus_read(hbase(1) + 16'h18, d); check("R9 hart1 routing", d, tw(4, 1));
    bus_write(taddr(5), 32'd0);
    pend(8'b0001_0000);
    bus_read(hbase(0) + 16'h18, d); check("R3 prio0 as 1", d, tw(5, 1));
    src_en[4] = 1'b0;
    bus_read(hbase(0) + 16'h18, d); check("R9 disabled source", d, tw(2, 3));
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    bus_write(hbase(0) + 16'h08, 32'd3);
    bus_read(hbase(0) + 16'h18, d); check("R4 thr strict", d, 32'd0);
    bus_write(hbase(0) + 16'h08, 32'd4);
    bus_read(hbase(0) + 16'h18, d); check("R4 thr pass", d, tw(2, 3));
    bus_write(hbase(0) + 16'h08, 32'd0);
    bus_read(hbase(0) + 16'h18, d); check("R4 thr off", d, tw(2, 3));
  endtask

  task automatic t_claim();
    logic [31:0] d;
    bus_read(hbase(0) + 16'h1C, d); check("R6 claim value", d, tw(2, 3));
    bus_read(hbase(0) + 16'h18, d); check("R6 cleared 2", d, tw(3, 3));
    bus_read(hbase(0) + 16'h1C, d); check("R6 claim 3", d, tw(3, 3));
    bus_read(hbase(0) + 16'h1C, d); check("R6 claim 1", d, tw(1, 5));
    bus_read(hbase(0) + 16'h18, d); check("R6 empty", d, 32'd0);
    pend(8'b0000_0001);
    src_pend_set = 8'b0000_0001;
    bus_read(hbase(0) + 16'h1C, d);
    src_pend_set = '0;
    check("R6 claim with set", d, tw(1, 5));
    bus_read(hbase(0) + 16'h18, d); check("R6 set wins", d, tw(1, 5));
    bus_read(hbase(0) + 16'h1C, d);
    bus_read(hbase(1) + 16'h1C, d); check("R6 claim hart1", d, tw(4, 1));
  endtask

  task automatic t_deliver();
    logic [31:0] d;
    pend(8'b0000_0010);
    check("R7 blocked", 32'(hart_irq), 32'd0);
    bus_read(hbase(0) + 16'h18, d); check("R7 top while blocked", d, tw(2, 3));
    bus_write(hbase(0), 32'd1);
    check("R7 delivered", 32'(hart_irq), 32'b01);
    bus_read(hbase(0), d); check("R7 enable readback", d, 32'd1);
    bus_write(hbase(0), 32'd0);
    check("R7 blocked again", 32'(hart_irq), 32'd0);
  endtask

  task automatic t_force();
    logic [31:0] d;
    bus_read(hbase(0) + 16'h1C, d);
    bus_write(hbase(0), 32'd1);
    bus_write(hbase(1), 32'd1);
    check("R8 idle", 32'(hart_irq), 32'd0);
    bus_write(hbase(1) + 16'h04, 32'd1);
    check("R8 forced", 32'(hart_irq), 32'b10);
    bus_read(hbase(1) + 16'h1C, d); check("R8 claim force", d, 32'd0);
    check("R8 force dropped", 32'(hart_irq), 32'd0);
    bus_read(hbase(1) + 16'h04, d); check("R8 force reg", d, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_en = '0; src_pend_set = '0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_target();
    t_select();
    t_threshold();
    t_claim();
    t_deliver();
    t_force();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule